// File: doc/BRIEF.md
# Serial Receive Double-Buffer Stage

This block is the hand-off point between a serial receiver and a host bus. When the shift logic finishes a word, it presents the word in parallel with a one-cycle valid pulse. The block keeps that word in a one-entry pending slot. As soon as the host-visible data registers are empty, it formats the word and moves it into a low/high pair of 16-bit data registers, then raises a ready flag.

The word is formatted during the move. Words of 16 bits or fewer use only the low register. Longer words also fill the high register, which takes the most significant bits. An 8-bit sample can be expanded from mu-law or A-law into 16-bit linear PCM. When companding is off, the word can be right-justified with zero fill, right-justified with sign extension, or left-justified with zero fill.

The host reads through an address plus a read strobe. A strobed read of the low register empties the data pair and lets the next pending word move in. For long words the host must read the high half first.

Top module: `rxbuf_stage`

## Requirements
- R1: While the ready flag is high, the data registers keep their contents. A newly arrived word waits in the pending slot.
- R2: When a pending word is moved into the data registers, `rxReady` goes high in the following cycle. The word becomes visible at `rdData` in that same cycle.
- R3: `lenSel` selects the word length: 0=8, 1=12, 2=16, 3=20, 4=24 bits, any other code means 32 bits. Input bits above the word length are ignored. For lengths of 16 or less, the high register (`rdAddr`=1) reads 0. For longer lengths, the high register holds bits above bit 15 of the formatted word. `rdAddr`=0 selects the low register.
- R4: With `compandMode`=10b and an 8-bit length, the low register receives the mu-law expansion of the 8-bit code as 16-bit linear PCM. For example, 0x00 gives 0x8284, 0x80 gives 0x7D7C and 0xFF gives 0x0000.
- R5: With `compandMode`=11b and an 8-bit length, the low register receives the A-law expansion. For example, 0xD5 gives 0x0008, 0x55 gives 0xFFF8, 0xAA gives 0x7E00 and 0x2A gives 0x8200.
- R6: `compandMode` has no effect unless the length is 8 bits. With any other length, the word is justified according to `justMode`.
- R7: When companding is not in effect, `justMode`=00 right-justifies the word and fills the unused bits with zeros. Code 11 behaves the same as 00.
- R8: `justMode`=01 right-justifies the word and copies its top bit into all unused bits of the registers in use.
- R9: `justMode`=10 left-justifies the word with zeros below it. The word is aligned to the top of the low register for lengths of 16 or less, and to the top of the register pair for longer lengths.
- R10: A cycle with `rdEn` high and `rdAddr`=0 clears `rxReady` at the next edge, which releases the next move. A strobed read of the high register leaves `rxReady` set.
- R11: If a word arrives while the data registers are full and the pending slot is occupied, `overrun` is set and stays set until reset. The new word is discarded and the older pending word is kept.
- R12: Synchronous reset clears the data registers, the pending slot, `rxReady` and `overrun`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bufWord | input | 32 | Completed receive word, right-aligned |
| bufValid | input | 1 | One-cycle pulse marking `bufWord` valid |
| lenSel | input | 3 | Word length code |
| compandMode | input | 2 | 0x: off, 10: mu-law, 11: A-law |
| justMode | input | 2 | Justification and fill mode |
| rdEn | input | 1 | Host read strobe |
| rdAddr | input | 1 | 0: low data register, 1: high data register |
| rdData | output | 16 | Selected data register contents |
| rxReady | output | 1 | Data registers hold an unread word |
| overrun | output | 1 | Sticky overrun flag |

## Verification
The assertions check the handshake on every cycle:
- the data registers hold still while the ready flag is set;
- the ready flag rises after a pending word finds the data registers empty;
- a low read clears the ready flag, and a high read leaves it set;
- the overrun flag is set on a collision and then stays set;
- reset clears the ready and overrun flags.

Only the bench scenarios can show the formatted values. These are the mu-law and A-law expansion results, the three justification modes at short and long word lengths, and companding being ignored at other lengths. The bench also shows that the older pending word survives an overrun while the colliding word is dropped.

// File: rtl/rxbuf_pkg.sv
package rxbuf_pkg;

  typedef struct packed {
    logic loadPend;  // capture incoming word into pending slot
    logic doCopy;    // move pending word into data registers
  } rxStrobe_t;

  function automatic int wordLenBits(input logic [2:0] sel);
    case (sel)
      3'd0: return 8;
      3'd1: return 12;
      3'd2: return 16;
      3'd3: return 20;
      3'd4: return 24;
      default: return 32;
    endcase
  endfunction

  // mu-law code to 16-bit linear
  function automatic logic [15:0] muExpand(input logic [7:0] code);
    logic [7:0]  inv;
    logic [15:0] mag;
    inv = ~code;
    mag = ({9'd0, inv[3:0], 3'b000} + 16'd132) << inv[6:4];
    return inv[7] ? (16'd132 - mag) : (mag - 16'd132);
  endfunction

  // A-law code to 16-bit linear
  function automatic logic [15:0] aExpand(input logic [7:0] code);
    logic [7:0]  flip;
    logic [15:0] mag;
    flip = code ^ 8'h55;
    mag  = {8'd0, flip[3:0], 4'b0000};
    if (flip[6:4] == 3'd0) mag = mag + 16'd8;
    else                   mag = (mag + 16'h0108) << (flip[6:4] - 3'd1);
    return flip[7] ? mag : (16'd0 - mag);
  endfunction

endpackage

// File: rtl/rxbuf_ctrl.sv
module rxbuf_ctrl (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  bufValid,
  input  logic                  rdLow,
  output rxbuf_pkg::rxStrobe_t  strobe,
  output logic                  pendValid,
  output logic                  dataFull,
  output logic                  overrun
);
  logic collide;

  always_comb begin
    strobe.doCopy   = pendValid && !dataFull;
    strobe.loadPend = bufValid && (!pendValid || strobe.doCopy);
    collide         = bufValid && pendValid && !strobe.doCopy;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pendValid <= 1'b0;
      dataFull  <= 1'b0;
      overrun   <= 1'b0;
    end else begin
      if (strobe.loadPend)    pendValid <= 1'b1;
      else if (strobe.doCopy) pendValid <= 1'b0;

      if (strobe.doCopy)      dataFull <= 1'b1;
      else if (rdLow)         dataFull <= 1'b0;

      if (collide)            overrun <= 1'b1;
    end
  end
endmodule

// File: rtl/rxbuf_datapath.sv
module rxbuf_datapath #(
  parameter int DATA_W = 32
) (
  input  logic                  clk,
  input  logic                  rst,
  input  rxbuf_pkg::rxStrobe_t  strobe,
  input  logic [DATA_W-1:0]     bufWord,
  input  logic [2:0]            lenSel,
  input  logic [1:0]            compandMode,
  input  logic [1:0]            justMode,
  input  logic                  rdHigh,
  output logic [DATA_W/2-1:0]   dataLo,
  output logic [DATA_W/2-1:0]   dataHi,
  output logic [DATA_W/2-1:0]   rdData
);
  localparam int HALF_W = DATA_W / 2;
  localparam int IDX_W  = $clog2(DATA_W);

  logic [DATA_W-1:0] pendWord;
  logic [DATA_W-1:0] lenMask, masked, shaped;
  logic [HALF_W-1:0] nextLo, nextHi;
  logic              topBit;
  int                lenBits;

  always_ff @(posedge clk) begin
    if (rst)                  pendWord <= '0;
    else if (strobe.loadPend) pendWord <= bufWord;
  end

  always_comb begin
    lenBits = rxbuf_pkg::wordLenBits(lenSel);
    lenMask = (lenBits >= DATA_W) ? '1 : ((DATA_W'(1) << lenBits) - DATA_W'(1));
    masked  = pendWord & lenMask;
    topBit  = pendWord[IDX_W'(lenBits - 1)];
    case (justMode)
      2'b01:   shaped = topBit ? (masked | ~lenMask) : masked;
      2'b10:   shaped = (lenBits <= HALF_W) ? (masked << (HALF_W - lenBits))
                                            : (masked << (DATA_W - lenBits));
      default: shaped = masked;
    endcase

    if (compandMode[1] && lenBits == 8) begin
      nextLo = compandMode[0] ? HALF_W'(rxbuf_pkg::aExpand(pendWord[7:0]))
                              : HALF_W'(rxbuf_pkg::muExpand(pendWord[7:0]));
      nextHi = '0;
    end else begin
      nextLo = shaped[HALF_W-1:0];
      nextHi = (lenBits > HALF_W) ? shaped[DATA_W-1:HALF_W] : '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dataLo <= '0;
      dataHi <= '0;
    end else if (strobe.doCopy) begin
      dataLo <= nextLo;
      dataHi <= nextHi;
    end
  end

  assign rdData = rdHigh ? dataHi : dataLo;
endmodule

// File: rtl/rxbuf_stage.sv
module rxbuf_stage #(
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [DATA_W-1:0]   bufWord,
  input  logic                bufValid,
  input  logic [2:0]          lenSel,
  input  logic [1:0]          compandMode,
  input  logic [1:0]          justMode,
  input  logic                rdEn,
  input  logic                rdAddr,
  output logic [DATA_W/2-1:0] rdData,
  output logic                rxReady,
  output logic                overrun
);
  rxbuf_pkg::rxStrobe_t strobe;
  logic                 pendValid;
  logic                 dataFull;
  logic [DATA_W/2-1:0]  dataLo, dataHi;

  rxbuf_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .bufValid  (bufValid),
    .rdLow     (rdEn && !rdAddr),
    .strobe    (strobe),
    .pendValid (pendValid),
    .dataFull  (dataFull),
    .overrun   (overrun)
  );

  rxbuf_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk         (clk),
    .rst         (rst),
    .strobe      (strobe),
    .bufWord     (bufWord),
    .lenSel      (lenSel),
    .compandMode (compandMode),
    .justMode    (justMode),
    .rdHigh      (rdAddr),
    .dataLo      (dataLo),
    .dataHi      (dataHi),
    .rdData      (rdData)
  );

  assign rxReady = dataFull;
endmodule

// File: rtl/rxbuf_checker.sv
module rxbuf_checker #(
  parameter int DATA_W = 32
) (
  input logic                clk,
  input logic                rst,
  input logic                bufValid,
  input logic                rdEn,
  input logic                rdAddr,
  input logic                rxReady,
  input logic                overrun,
  input logic                pendValid,
  input logic [DATA_W/2-1:0] dataLo,
  input logic [DATA_W/2-1:0] dataHi
);
  // R1
  data_hold_chk: assert property (@(posedge clk) disable iff (rst)
    rxReady |=> ($stable(dataLo) && $stable(dataHi)));

  // R2
  ready_rise_chk: assert property (@(posedge clk) disable iff (rst)
    (pendValid && !rxReady) |=> rxReady);

  // R10
  low_read_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (rxReady && rdEn && !rdAddr) |=> !rxReady);

  // R10
  ready_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (rxReady && !(rdEn && !rdAddr)) |=> rxReady);

  // R11
  overrun_set_chk: assert property (@(posedge clk) disable iff (rst)
    (bufValid && pendValid && rxReady) |=> overrun);

  // R11
  overrun_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    overrun |=> overrun);

  // R12
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!rxReady && !overrun && !pendValid));
endmodule

bind rxbuf_stage rxbuf_checker #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bufValid  (bufValid),
  .rdEn      (rdEn),
  .rdAddr    (rdAddr),
  .rxReady   (rxReady),
  .overrun   (overrun),
  .pendValid (pendValid),
  .dataLo    (dataLo),
  .dataHi    (dataHi)
);

// File: tb/tb_rxbuf_stage.sv
module tb_rxbuf_stage;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic [31:0] bufWord;
  logic        bufValid;
  logic [2:0]  lenSel;
  logic [1:0]  compandMode;
  logic [1:0]  justMode;
  logic        rdEn;
  logic        rdAddr;
  logic [15:0] rdData;
  logic        rxReady;
  logic        overrun;

  int  nChecks = 0;
  int  nFails  = 0;
  bit  finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rxbuf_stage dut (
    .clk(clk), .rst(rst), .bufWord(bufWord), .bufValid(bufValid),
    .lenSel(lenSel), .compandMode(compandMode), .justMode(justMode),
    .rdEn(rdEn), .rdAddr(rdAddr), .rdData(rdData),
    .rxReady(rxReady), .overrun(overrun)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic setCfg(input logic [2:0] l, input logic [1:0] c, input logic [1:0] j);
    lenSel = l; compandMode = c; justMode = j;
  endtask

  // word enters pending slot at one edge and is moved at the next
  task automatic pushWord(input logic [31:0] w);
    bufWord = w; bufValid = 1'b1;
    @(posedge clk); @(negedge clk);
    bufValid = 1'b0;
  endtask

  task automatic deliver(input logic [31:0] w);
    pushWord(w);
    @(posedge clk); @(negedge clk);
  endtask

  task automatic peek(input logic a, output logic [15:0] v);
    rdAddr = a; rdEn = 1'b0;
    #1 v = rdData;
  endtask

  task automatic strobeRead(input logic a);
    rdAddr = a; rdEn = 1'b1;
    @(posedge clk); @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic expectWord(input string tag, input logic [15:0] hi, input logic [15:0] lo);
    logic [15:0] v;
    check({tag, " ready"}, {31'd0, rxReady}, 32'd1);
    peek(1'b1, v); check({tag, " high"}, {16'd0, v}, {16'd0, hi});
    peek(1'b0, v); check({tag, " low"},  {16'd0, v}, {16'd0, lo});
    strobeRead(1'b1);
    strobeRead(1'b0);
  endtask

  task automatic t_reset;
    logic [15:0] v;
    rst = 1'b1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    rst = 1'b0;
    check("R12 ready after reset", {31'd0, rxReady}, 32'd0);
    check("R12 overrun after reset", {31'd0, overrun}, 32'd0);
    peek(1'b0, v); check("R12 low after reset", {16'd0, v}, 32'd0);
    peek(1'b1, v); check("R12 high after reset", {16'd0, v}, 32'd0);
  endtask

  task automatic t_zeroFill;
    setCfg(3'd1, 2'b00, 2'b00);
    deliver(32'hFFFF_FA5C);
    expectWord("R7 R3 R2 len12 zero fill", 16'h0000, 16'h0A5C);
    check("R10 ready cleared by low read", {31'd0, rxReady}, 32'd0);
    setCfg(3'd4, 2'b00, 2'b00);
    deliver(32'h008A_BCDE);
    expectWord("R7 R3 len24 zero fill", 16'h008A, 16'hBCDE);
    setCfg(3'd5, 2'b00, 2'b11);
    deliver(32'h1234_5678);
    expectWord("R7 R3 len32 mode11", 16'h1234, 16'h5678);
    setCfg(3'd0, 2'b00, 2'b00);
    deliver(32'hFFFF_FF12);
    expectWord("R3 len8 upper bits ignored", 16'h0000, 16'h0012);
  endtask

  task automatic t_signExt;
    setCfg(3'd1, 2'b00, 2'b01);
    deliver(32'h0000_0A5C);
    expectWord("R8 len12 sign", 16'h0000, 16'hFA5C);
    setCfg(3'd4, 2'b00, 2'b01);
    deliver(32'h008A_BCDE);
    expectWord("R8 len24 sign", 16'hFF8A, 16'hBCDE);
    setCfg(3'd2, 2'b00, 2'b01);
    deliver(32'h0000_7001);
    expectWord("R8 len16 positive", 16'h0000, 16'h7001);
  endtask

  task automatic t_leftJust;
    setCfg(3'd1, 2'b00, 2'b10);
    deliver(32'h0000_0A5C);
    expectWord("R9 len12 left", 16'h0000, 16'hA5C0);
    setCfg(3'd4, 2'b00, 2'b10);
    deliver(32'h008A_BCDE);
    expectWord("R9 len24 left", 16'h8ABC, 16'hDE00);
  endtask

  task automatic t_muLaw;
    setCfg(3'd0, 2'b10, 2'b00);
    deliver(32'h0000_0000); expectWord("R4 mu 0x00", 16'h0000, 16'h8284);
    deliver(32'h0000_0080); expectWord("R4 mu 0x80", 16'h0000, 16'h7D7C);
    deliver(32'h0000_00FF); expectWord("R4 mu 0xFF", 16'h0000, 16'h0000);
  endtask

  task automatic t_aLaw;
    setCfg(3'd0, 2'b11, 2'b01);
    deliver(32'h0000_00D5); expectWord("R5 A 0xD5", 16'h0000, 16'h0008);
    deliver(32'h0000_0055); expectWord("R5 A 0x55", 16'h0000, 16'hFFF8);
    deliver(32'h0000_00AA); expectWord("R5 A 0xAA", 16'h0000, 16'h7E00);
    deliver(32'h0000_002A); expectWord("R5 A 0x2A", 16'h0000, 16'h8200);
  endtask

  task automatic t_compandIgnored;
    setCfg(3'd1, 2'b10, 2'b00);
    deliver(32'h0000_00FF);
    expectWord("R6 mu ignored at len12", 16'h0000, 16'h00FF);
    setCfg(3'd2, 2'b11, 2'b10);
    deliver(32'h0000_00D5);
    expectWord("R6 A ignored at len16", 16'h0000, 16'h00D5);
  endtask

  task automatic t_highReadKeeps;
    logic [15:0] v;
    setCfg(3'd5, 2'b00, 2'b00);
    deliver(32'hCAFE_F00D);
    strobeRead(1'b1);
    check("R10 high read keeps ready", {31'd0, rxReady}, 32'd1);
    peek(1'b0, v); check("R10 low intact after high read", {16'd0, v}, 32'h0000_F00D);
    strobeRead(1'b0);
    check("R10 low read clears ready", {31'd0, rxReady}, 32'd0);
  endtask

  task automatic t_holdOverrun;
    logic [15:0] v;
    setCfg(3'd2, 2'b00, 2'b00);
    deliver(32'h0000_0111);
    pushWord(32'h0000_0222);
    @(posedge clk); @(negedge clk);
    peek(1'b0, v); check("R1 data held while full", {16'd0, v}, 32'h0000_0111);
    check("R11 no overrun with free slot", {31'd0, overrun}, 32'd0);
    pushWord(32'h0000_0333);
    check("R11 overrun set on collision", {31'd0, overrun}, 32'd1);
    strobeRead(1'b0);
    @(posedge clk); @(negedge clk);
    check("R2 ready after release", {31'd0, rxReady}, 32'd1);
    peek(1'b0, v); check("R11 older pending word kept", {16'd0, v}, 32'h0000_0222);
    strobeRead(1'b0);
    @(posedge clk); @(posedge clk); @(negedge clk);
    check("R11 colliding word dropped", {31'd0, rxReady}, 32'd0);
    check("R11 overrun sticky", {31'd0, overrun}, 32'd1);
    rst = 1'b1;
    @(posedge clk); @(negedge clk);
    rst = 1'b0;
    check("R12 reset clears overrun", {31'd0, overrun}, 32'd0);
  endtask

  initial begin
    rst = 1'b1; bufWord = '0; bufValid = 1'b0; rdEn = 1'b0; rdAddr = 1'b0;
    setCfg(3'd2, 2'b00, 2'b00);
    @(negedge clk);
    t_reset();
    t_zeroFill();
    t_signExt();
    t_leftJust();
    t_muLaw();
    t_aLaw();
    t_compandIgnored();
    t_highReadKeeps();
    t_holdOverrun();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end
endmodule